// File: doc/BRIEF.md
# Readout Line Window Masking Controller

This block sits beside a sensor readout sequencer and decides, for each line of a frame, whether that line is sent or skipped. A skipped line is dumped quickly instead of being read out, so every skipped line shortens the frame. Software sets up to five windows of line addresses. Each window covers the lines from its first line to its last line, both included. A separate window count selects how many of the entries in the table are in force.

Configuration passes through three register stages. Table writes fill a staging copy. A write of the count checks the value and copies the staging table and the count into a pending copy. The pending copy becomes the active one at the next frame start, so a frame in progress never sees a change. The block follows the line index, starting at 0 on each frame start and advancing on each line strobe. It reports whether the current line is skipped or sent and keeps a running count of the lines skipped so far in the frame. Table entries that break the alignment or ordering rules, and count values that are too large, are refused and flagged.

Top module: `line_window_mask`

## Requirements
- R1: After reset, no frame is in progress: `line_skip` and `line_xmit` are both 0, `masked_lines` is 0 and `cfg_reject` is 0.
- R2: A `frame_start` makes line 0 the current line and clears `masked_lines`. Each later `line_adv` moves to the next line. The flags always describe the current line, and they and the counter change only on those two strobes.
- R3: A current line L below 3500 is skipped when some active window i with i < active count has start_i <= L <= end_i. Both bounds are included, and overlapping windows combine by OR. Any other line below 3500 is sent.
- R4: An active count of 0 turns masking off, so every line of the frame is sent.
- R5: Table entries at positions equal to or above the active count have no effect on any line.
- R6: A table write is accepted only when all of these hold: index < 5, start is a multiple of 4, end mod 4 equals 3, start <= end, and end <= 3499. Otherwise `cfg_reject` is 1 in the cycle after the write and the stored entry keeps its old value. An accepted write leaves `cfg_reject` at 0.
- R7: A count write with a value above 5 is refused. `cfg_reject` is 1 in the next cycle, and neither the pending table nor the pending count changes.
- R8: Table writes do not reach the pending or active copy until a later accepted count write commits them.
- R9: A committed configuration takes effect only at the next `frame_start`. The frame already in progress keeps its windows.
- R10: `masked_lines` goes up by one on each `line_adv` that leaves a skipped line. With windows 0..303, 1376..2123 and 3196..3499, a full frame gives 1356.
- R11: Once line 3499 has been advanced past, both flags are 0. Further `line_adv` strobes are ignored and `masked_lines` holds until the next `frame_start`.
- R12: When `frame_start` and `line_adv` arrive in the same cycle, `frame_start` wins: the current line becomes 0 and the counter becomes 0.
- R13: `line_skip` and `line_xmit` are never 1 together. Inside a frame, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start-of-frame strobe: loads pending configuration, line 0 becomes current |
| line_adv | input | 1 | Line strobe: move to the next line |
| tbl_wr | input | 1 | Write strobe for one staging table entry |
| tbl_idx | input | 3 | Entry position 0..4 |
| tbl_start | input | 12 | First line of the window |
| tbl_end | input | 12 | Last line of the window (included) |
| cnt_wr | input | 1 | Count write: checks the value and commits staging to pending |
| cnt_val | input | 3 | Number of active windows, 0..5 |
| line_skip | output | 1 | Current line is inside an active window |
| line_xmit | output | 1 | Current line is in the frame and outside every active window |
| masked_lines | output | 12 | Lines skipped so far in this frame |
| cfg_reject | output | 1 | One-cycle pulse after a refused table or count write |

## Verification
The flags and the counter come from registers that update on the edge that samples `frame_start` or `line_adv`. The new values therefore appear one edge after the strobe. `cfg_reject` comes from a register written on the edge that samples the write, so it also appears one edge later. A committed configuration changes nothing until the edge that samples the next `frame_start`. The bench drives its inputs on falling edges. A behavioural model updates on each rising edge, and every output is compared with it on the next falling edge, half a cycle after each result is due. Directed checks step through the window boundaries one line at a time, so each one samples a known line index.

// File: rtl/lwm_pkg.sv
package lwm_pkg;

   // Largest window table the library block supports.
   localparam int unsigned LWM_WIN_LIMIT = 8;

   // True for 1, 2, 4, 8 ...
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Number of low address bits that must be zero (start) or all ones (end).
   function automatic int group_bits(input int grp);
      int n;
      n = 0;
      while ((1 << n) < grp) n++;
      return n;
   endfunction

endpackage

// File: rtl/lwm_entry_check.sv
module lwm_entry_check #(
   parameter int NUM_WIN   = 5,
   parameter int NUM_LINES = 3500,
   parameter int GROUP     = 4,
   parameter int LINE_W    = 12,
   parameter int IDX_W     = 3
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [LINE_W-1:0] first_line,
   input  logic [LINE_W-1:0] last_line,
   output logic              entry_ok
);
   localparam int GB = lwm_pkg::group_bits(GROUP);

   logic idx_ok, order_ok, range_ok, align_ok;

   assign idx_ok   = int'(idx) < NUM_WIN;
   assign order_ok = first_line <= last_line;
   assign range_ok = int'(last_line) < NUM_LINES;

   generate
      if (GB > 0) begin : g_aligned
         // Window must span whole groups of GROUP lines.
         assign align_ok = (first_line[GB-1:0] == '0) && (&last_line[GB-1:0]);
      end else begin : g_free
         assign align_ok = 1'b1;
      end
   endgenerate

   assign entry_ok = idx_ok && order_ok && range_ok && align_ok;
endmodule

// File: rtl/lwm_table.sv
module lwm_table #(
   parameter int NUM_WIN   = 5,
   parameter int NUM_LINES = 3500,
   parameter int GROUP     = 4,
   parameter int LINE_W    = 12,
   parameter int IDX_W     = 3,
   parameter int CNT_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              tbl_wr,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [LINE_W-1:0] tbl_start,
   input  logic [LINE_W-1:0] tbl_end,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_val,
   output logic [LINE_W-1:0] act_start [NUM_WIN],
   output logic [LINE_W-1:0] act_stop  [NUM_WIN],
   output logic [CNT_W-1:0]  act_cnt,
   output logic              cfg_reject
);
   logic entry_ok, cnt_ok, commit;
   logic [CNT_W-1:0] pend_cnt;

   lwm_entry_check #(
      .NUM_WIN(NUM_WIN), .NUM_LINES(NUM_LINES), .GROUP(GROUP),
      .LINE_W(LINE_W), .IDX_W(IDX_W)
   ) u_check (
      .idx(tbl_idx), .first_line(tbl_start), .last_line(tbl_end), .entry_ok(entry_ok)
   );

   assign cnt_ok = int'(cnt_val) <= NUM_WIN;
   assign commit = cnt_wr && cnt_ok;

   // One register slice per window entry: staging -> pending -> active.
   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_ent
         logic [LINE_W-1:0] stg_s, stg_e, pnd_s, pnd_e, act_s, act_e;
         logic sel;
         assign sel = tbl_wr && entry_ok && (tbl_idx == IDX_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stg_s <= '0; stg_e <= '0;
               pnd_s <= '0; pnd_e <= '0;
               act_s <= '0; act_e <= '0;
            end else begin
               if (frame_start) begin
                  act_s <= pnd_s;
                  act_e <= pnd_e;
               end
               if (commit) begin
                  pnd_s <= stg_s;
                  pnd_e <= stg_e;
               end
               if (sel) begin
                  stg_s <= tbl_start;
                  stg_e <= tbl_end;
               end
            end
         end

         assign act_start[i] = act_s;
         assign act_stop[i]  = act_e;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_cnt   <= '0;
         act_cnt    <= '0;
         cfg_reject <= 1'b0;
      end else begin
         if (frame_start) act_cnt  <= pend_cnt;
         if (commit)      pend_cnt <= cnt_val;
         cfg_reject <= (tbl_wr && !entry_ok) || (cnt_wr && !cnt_ok);
      end
   end
endmodule

// File: rtl/lwm_match.sv
module lwm_match #(
   parameter int NUM_WIN   = 5,
   parameter int NUM_LINES = 3500,
   parameter int LINE_W    = 12,
   parameter int CNT_W     = 3
) (
   input  logic [LINE_W-1:0] line_idx,
   input  logic [LINE_W-1:0] win_start [NUM_WIN],
   input  logic [LINE_W-1:0] win_stop  [NUM_WIN],
   input  logic [CNT_W-1:0]  win_cnt,
   output logic              line_skip,
   output logic              line_xmit
);
   logic [NUM_WIN-1:0] hit;
   logic in_range;

   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
         assign hit[i] = (win_cnt > CNT_W'(i)) &&
                         (line_idx >= win_start[i]) &&
                         (line_idx <= win_stop[i]);
      end
   endgenerate

   assign in_range  = line_idx < LINE_W'(NUM_LINES);
   assign line_skip = in_range && (|hit);
   assign line_xmit = in_range && !(|hit);
endmodule

// File: rtl/lwm_line_track.sv
module lwm_line_track #(
   parameter int NUM_LINES = 3500,
   parameter int LINE_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_adv,
   input  logic              cur_skip,
   output logic [LINE_W-1:0] line_idx,
   output logic [LINE_W-1:0] masked_lines
);
   localparam logic [LINE_W-1:0] IDLE_LINE = LINE_W'(NUM_LINES);

   logic in_range;
   assign in_range = line_idx < IDLE_LINE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_idx     <= IDLE_LINE;
         masked_lines <= '0;
      end else if (frame_start) begin
         line_idx     <= '0;
         masked_lines <= '0;
      end else if (line_adv && in_range) begin
         line_idx <= line_idx + 1'b1;
         if (cur_skip) masked_lines <= masked_lines + 1'b1;
      end
   end
endmodule

// File: rtl/line_window_mask.sv
module line_window_mask #(
   parameter int NUM_WIN   = 5,
   parameter int NUM_LINES = 3500,
   parameter int GROUP     = 4,
   localparam int LINE_W   = $clog2(NUM_LINES + 1),
   localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int CNT_W    = $clog2(NUM_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_adv,
   input  logic              tbl_wr,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [LINE_W-1:0] tbl_start,
   input  logic [LINE_W-1:0] tbl_end,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_val,
   output logic              line_skip,
   output logic              line_xmit,
   output logic [LINE_W-1:0] masked_lines,
   output logic              cfg_reject
);
   generate
      if (NUM_WIN < 1 || NUM_WIN > int'(lwm_pkg::LWM_WIN_LIMIT)) begin : g_bad_win
         $error("line_window_mask: NUM_WIN out of supported range");
      end
      if (!lwm_pkg::is_pow2(GROUP)) begin : g_bad_grp
         $error("line_window_mask: GROUP must be a power of two");
      end
      if (NUM_LINES < GROUP) begin : g_bad_lines
         $error("line_window_mask: NUM_LINES smaller than one group");
      end
   endgenerate

   logic [LINE_W-1:0] act_start [NUM_WIN];
   logic [LINE_W-1:0] act_stop  [NUM_WIN];
   logic [CNT_W-1:0]  act_cnt;
   logic [LINE_W-1:0] line_idx;

   lwm_table #(
      .NUM_WIN(NUM_WIN), .NUM_LINES(NUM_LINES), .GROUP(GROUP),
      .LINE_W(LINE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_start(tbl_start), .tbl_end(tbl_end),
      .cnt_wr(cnt_wr), .cnt_val(cnt_val),
      .act_start(act_start), .act_stop(act_stop), .act_cnt(act_cnt),
      .cfg_reject(cfg_reject)
   );

   lwm_match #(
      .NUM_WIN(NUM_WIN), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .CNT_W(CNT_W)
   ) u_match (
      .line_idx(line_idx), .win_start(act_start), .win_stop(act_stop),
      .win_cnt(act_cnt), .line_skip(line_skip), .line_xmit(line_xmit)
   );

   lwm_line_track #(
      .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
      .cur_skip(line_skip), .line_idx(line_idx), .masked_lines(masked_lines)
   );
endmodule

// File: rtl/lwm_checker.sv
module lwm_checker #(
   parameter int NUM_WIN = 5,
   parameter int LINE_W  = 12,
   parameter int CNT_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              line_adv,
   input logic              tbl_wr,
   input logic [LINE_W-1:0] tbl_start,
   input logic [LINE_W-1:0] tbl_end,
   input logic              cnt_wr,
   input logic [CNT_W-1:0]  cnt_val,
   input logic              line_skip,
   input logic              line_xmit,
   input logic [LINE_W-1:0] masked_lines,
   input logic              cfg_reject
);
   assert_flags_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_skip && line_xmit));

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (masked_lines == '0) && (line_skip || line_xmit));

   assert_start_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && line_adv) |=> masked_lines == '0);

   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (line_adv && line_skip && !frame_start) |=>
         masked_lines == LINE_W'($past(masked_lines) + 1'b1));

   assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_adv && !frame_start) |=>
         ($stable(masked_lines) && $stable(line_skip) && $stable(line_xmit)));

   assert_order_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_wr && (tbl_start > tbl_end)) |=> cfg_reject);

   assert_count_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && (int'(cnt_val) > NUM_WIN)) |=> cfg_reject);

   assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_skip && !line_xmit && !frame_start) |=> (!line_skip && !line_xmit));
endmodule

bind line_window_mask lwm_checker #(
   .NUM_WIN(NUM_WIN), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
   .tbl_wr(tbl_wr), .tbl_start(tbl_start), .tbl_end(tbl_end),
   .cnt_wr(cnt_wr), .cnt_val(cnt_val),
   .line_skip(line_skip), .line_xmit(line_xmit),
   .masked_lines(masked_lines), .cfg_reject(cfg_reject)
);

// File: tb/sim_line_window_mask.sv
module sim_line_window_mask;
   localparam int NW = 5;
   localparam int NL = 3500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, line_adv = 1'b0, tbl_wr = 1'b0, cnt_wr = 1'b0;
   logic [2:0]  tbl_idx = '0;
   logic [11:0] tbl_start = '0, tbl_end = '0;
   logic [2:0]  cnt_val = '0;
   logic        line_skip, line_xmit, cfg_reject;
   logic [11:0] masked_lines;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   line_window_mask u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
      .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_start(tbl_start), .tbl_end(tbl_end),
      .cnt_wr(cnt_wr), .cnt_val(cnt_val),
      .line_skip(line_skip), .line_xmit(line_xmit),
      .masked_lines(masked_lines), .cfg_reject(cfg_reject)
   );

   // Behavioural reference: three copies of the table, a line number and a tally.
   int st_s[NW], st_e[NW], pd_s[NW], pd_e[NW], ac_s[NW], ac_e[NW];
   int pd_n, ac_n, m_line, m_cnt;
   bit m_rej;
   bit m_sk;

   function automatic bit ref_skip(int ln);
      bit h = 0;
      if (ln >= NL) return 0;
      for (int i = 0; i < ac_n; i++)
         if (ln >= ac_s[i] && ln <= ac_e[i]) h = 1;
      return h;
   endfunction

   function automatic bit ref_ok(int idx, int s, int e);
      return (idx < NW) && (s % 4 == 0) && (e % 4 == 3) && (s <= e) && (e < NL);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) begin
            st_s[i] = 0; st_e[i] = 0; pd_s[i] = 0; pd_e[i] = 0; ac_s[i] = 0; ac_e[i] = 0;
         end
         pd_n = 0; ac_n = 0; m_line = NL; m_cnt = 0; m_rej = 0;
      end else begin
         m_sk = ref_skip(m_line);
         if (frame_start) begin
            ac_s = pd_s; ac_e = pd_e; ac_n = pd_n;
         end
         m_rej = 0;
         if (cnt_wr) begin
            if (int'(cnt_val) <= NW) begin
               pd_s = st_s; pd_e = st_e; pd_n = int'(cnt_val);
            end else m_rej = 1;
         end
         if (tbl_wr) begin
            if (ref_ok(int'(tbl_idx), int'(tbl_start), int'(tbl_end))) begin
               st_s[tbl_idx] = int'(tbl_start); st_e[tbl_idx] = int'(tbl_end);
            end else m_rej = 1;
         end
         if (frame_start) begin
            m_line = 0; m_cnt = 0;
         end else if (line_adv && m_line < NL) begin
            if (m_sk) m_cnt++;
            m_line++;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
      end
   endtask

   // Every-cycle comparison with the model, half a cycle after each edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 skip flag", int'(line_skip), int'(ref_skip(m_line)));
         chk("R13 send flag", int'(line_xmit), int'((m_line < NL) && !ref_skip(m_line)));
         chk("R10 masked count", int'(masked_lines), m_cnt);
         chk("R6 reject pulse", int'(cfg_reject), int'(m_rej));
      end
   end

   task automatic pulse_fs();
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
   endtask

   task automatic adv(int n);
      @(negedge clk); line_adv = 1;
      repeat (n) @(negedge clk);
      line_adv = 0;
   endtask

   task automatic wr_tbl(int idx, int s, int e);
      @(negedge clk);
      tbl_wr = 1; tbl_idx = 3'(idx); tbl_start = 12'(s); tbl_end = 12'(e);
      @(negedge clk); tbl_wr = 0;
   endtask

   task automatic wr_cnt(int v);
      @(negedge clk); cnt_wr = 1; cnt_val = 3'(v);
      @(negedge clk); cnt_wr = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 skip after reset", int'(line_skip), 0);
      chk("R1 send after reset", int'(line_xmit), 0);
      chk("R1 count after reset", int'(masked_lines), 0);
      chk("R1 reject after reset", int'(cfg_reject), 0);

      // R4: count 0, everything sent
      pulse_fs();
      chk("R4 line 0 sent", int'(line_xmit), 1);
      adv(10);
      chk("R4 line 10 sent", int'(line_xmit), 1);
      chk("R4 nothing masked", int'(masked_lines), 0);

      // R8: staged entries without commit have no effect
      wr_tbl(0, 0, 303);
      chk("R6 good entry not refused", int'(cfg_reject), 0);
      wr_tbl(1, 1376, 2123);
      wr_tbl(2, 3196, 3499);
      pulse_fs();
      chk("R8 staged table ignored", int'(line_xmit), 1);

      // R9: commit mid-frame does not alter current frame
      wr_cnt(3);
      chk("R9 current frame unchanged", int'(line_xmit), 1);
      pulse_fs();
      chk("R2 count cleared at start", int'(masked_lines), 0);
      chk("R3 line 0 skipped", int'(line_skip), 1);
      adv(303);
      chk("R3 line 303 skipped", int'(line_skip), 1);
      adv(1);
      chk("R3 line 304 sent", int'(line_xmit), 1);
      adv(1072);
      chk("R3 line 1376 skipped", int'(line_skip), 1);
      adv(748);
      chk("R3 line 2124 sent", int'(line_xmit), 1);
      adv(1375);
      chk("R3 line 3499 skipped", int'(line_skip), 1);
      chk("R10 count before last", int'(masked_lines), 1355);
      adv(1);
      chk("R10 full frame total", int'(masked_lines), 1356);
      chk("R11 skip low after end", int'(line_skip), 0);
      chk("R11 send low after end", int'(line_xmit), 0);
      adv(5);
      chk("R11 count held", int'(masked_lines), 1356);
      chk("R11 send still low", int'(line_xmit), 0);

      // R6 / R7: refused writes
      wr_tbl(0, 5, 303);
      chk("R6 misaligned start refused", int'(cfg_reject), 1);
      wr_tbl(0, 304, 303);
      chk("R6 reversed bounds refused", int'(cfg_reject), 1);
      wr_tbl(1, 1376, 3503);
      chk("R6 end beyond last line refused", int'(cfg_reject), 1);
      wr_tbl(5, 0, 3);
      chk("R6 bad index refused", int'(cfg_reject), 1);
      wr_cnt(6);
      chk("R7 large count refused", int'(cfg_reject), 1);
      pulse_fs();
      chk("R7 active table kept", int'(line_skip), 1);
      wr_cnt(3);
      pulse_fs();
      chk("R6 entry 0 unchanged", int'(line_skip), 1);
      adv(1376);
      chk("R6 entry 1 unchanged", int'(line_skip), 1);

      // R5: only first entry active
      wr_cnt(1);
      pulse_fs();
      chk("R5 entry 0 active", int'(line_skip), 1);
      adv(1376);
      chk("R5 entry 1 inactive", int'(line_xmit), 1);

      // R3 overlap OR
      wr_tbl(1, 200, 399);
      wr_cnt(2);
      pulse_fs();
      adv(NL);
      chk("R3 overlapping windows total", int'(masked_lines), 400);

      // R12: start beats advance
      pulse_fs();
      adv(10);
      @(negedge clk); frame_start = 1; line_adv = 1;
      @(negedge clk); frame_start = 0; line_adv = 0;
      chk("R12 count zero", int'(masked_lines), 0);
      chk("R12 at line 0", int'(line_skip), 1);
      adv(400);
      chk("R12 line index restarted", int'(masked_lines), 400);
      chk("R3 line 400 sent", int'(line_xmit), 1);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule